// File: doc/BRIEF.md
# Two-Level Privilege Mode Tracker

This block holds the running privilege level of a small core that has only a machine level and a user level, together with the status bits that go with trap handling: a global interrupt enable, its saved copy, the saved privilege level, a modify-privilege bit that redirects load/store checks to the saved level, and a trap-wait bit that makes wait-for-interrupt illegal in user mode. It updates these bits when the core takes a trap and when it runs a trap-return instruction. It also cleans up software writes to the status word so that the saved privilege field can only ever hold a supported level.

The block also judges privilege rules for the decode stage. It flags CSR accesses whose address asks for a higher level than the current one, and writes to read-only CSR addresses. It flags trap-return and wait-for-interrupt instructions that user mode may not run, and gives the cause code for an environment call. It drives three privilege views: fetch sees the next-state level, decode sees the registered level, and load/store sees the saved level when modify-privilege is set.

Top module: `priv_mode_tracker`

## Requirements
- R1: After reset the current level is machine (2'b11). The status word reads 0x0000_0080: previous interrupt enable (bit 7) is set, interrupt enable (bit 3) is clear, saved level (bits 12:11) is user (2'b00), and modify-privilege (bit 17) and trap-wait (bit 21) are clear.
- R2: On trap entry the next current level is machine. The saved level takes the old current level, previous interrupt enable takes the old interrupt enable, and interrupt enable clears.
- R3: On trap return, when trap entry is not asserted, the current level takes the saved level and interrupt enable takes previous interrupt enable. Previous interrupt enable then becomes 1 and the saved level becomes user.
- R4: A status write loads bits 3, 7, 12:11, 17 and 21 from the write data. A saved-level value of 2'b01 or 2'b10 is stored as machine (2'b11). Reads return these five fields at those positions and zero in every other bit.
- R5: The CSR illegal flag is raised when a CSR access is requested and address bits 9:8, read as an unsigned number, exceed the current level. It is never raised when no access is requested.
- R6: The CSR illegal flag is also raised for a requested write to an address whose bits 11:10 are 2'b11, whatever the current level.
- R7: Outside machine level the instruction illegal flag is raised for trap return, and for wait-for-interrupt while trap-wait is set. In machine level it is never raised.
- R8: The environment-call cause is 11 in machine level and 8 in user level.
- R9: The fetch view equals the current level the next clock edge will load, in the same cycle. The decode view equals the registered current level.
- R10: The load/store view equals the saved level when modify-privilege is set, and the current level otherwise.
- R11: Trap entry takes priority over trap return, and both take priority over a status write in the same cycle. The write is then discarded entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronously released |
| trap_enter_i | input | 1 | Trap is taken this cycle |
| trap_return_i | input | 1 | Trap-return instruction retires this cycle |
| status_wr_i | input | 1 | Software write to the status word |
| status_wdata_i | input | XLEN | Status write data |
| status_rdata_o | output | XLEN | Status read value |
| csr_access_i | input | 1 | A CSR access is requested |
| csr_addr_i | input | ADDR_W | CSR address of the access |
| csr_write_i | input | 1 | The requested access writes |
| insn_mret_i | input | 1 | Decoded instruction is a trap return |
| insn_wfi_i | input | 1 | Decoded instruction is wait-for-interrupt |
| csr_illegal_o | output | 1 | CSR access violates privilege or read-only rule |
| insn_illegal_o | output | 1 | Instruction not allowed at current level |
| ecall_cause_o | output | CAUSE_W | Cause code for an environment call |
| priv_fetch_o | output | 2 | Next-state level for fetch |
| priv_decode_o | output | 2 | Registered level for decode |
| priv_lsu_o | output | 2 | Effective level for load/store checks |

## Verification
Trap entry, trap return and a status write can all arrive in the same cycle. The bench drives every combination of the three from both levels, with write data that would change every field. It then compares the status word and the three views against a model that applies entry, then return, then write as a strict priority. A long pseudo-random run mixes these events with single CSR and instruction rule probes. Exhaustive sweeps of the CSR address level bits, write flag and access flag are run at each level and trap-wait setting.

// File: rtl/priv_pkg.sv
package priv_pkg;

  localparam logic [1:0] LVL_MACHINE = 2'b11;
  localparam logic [1:0] LVL_USER    = 2'b00;

  // Status word bit positions (software visible layout)
  localparam int unsigned ST_IE_BIT    = 3;
  localparam int unsigned ST_PIE_BIT   = 7;
  localparam int unsigned ST_PLVL_LO   = 11;
  localparam int unsigned ST_PLVL_HI   = 12;
  localparam int unsigned ST_MODPRV_BIT = 17;
  localparam int unsigned ST_TWAIT_BIT = 21;
  localparam int unsigned ST_MIN_XLEN  = ST_TWAIT_BIT + 1;

  localparam int unsigned CAUSE_ENV_USER    = 8;
  localparam int unsigned CAUSE_ENV_MACHINE = 11;

  typedef struct packed {
    logic       twait;
    logic       modprv;
    logic [1:0] plvl;
    logic       pie;
    logic       ie;
  } stat_t;

  function automatic logic [1:0] legalize_lvl(input logic [1:0] v);
    return ((v == LVL_MACHINE) || (v == LVL_USER)) ? v : LVL_MACHINE;
  endfunction

endpackage

// File: rtl/priv_status_io.sv
module priv_status_io
  import priv_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] wdata_i,
  input  stat_t           stat_q_i,
  output stat_t           wfield_o,
  output logic [XLEN-1:0] rdata_o
);

  logic unused_wbits;
  assign unused_wbits = ^wdata_i;

  assign wfield_o.ie     = wdata_i[ST_IE_BIT];
  assign wfield_o.pie    = wdata_i[ST_PIE_BIT];
  assign wfield_o.plvl   = wdata_i[ST_PLVL_HI:ST_PLVL_LO];
  assign wfield_o.modprv = wdata_i[ST_MODPRV_BIT];
  assign wfield_o.twait  = wdata_i[ST_TWAIT_BIT];

  for (genvar b = 0; b < XLEN; b++) begin : g_rbit
    if (b == ST_IE_BIT) begin : g_ie
      assign rdata_o[b] = stat_q_i.ie;
    end else if (b == ST_PIE_BIT) begin : g_pie
      assign rdata_o[b] = stat_q_i.pie;
    end else if (b == ST_PLVL_LO) begin : g_pl0
      assign rdata_o[b] = stat_q_i.plvl[0];
    end else if (b == ST_PLVL_HI) begin : g_pl1
      assign rdata_o[b] = stat_q_i.plvl[1];
    end else if (b == ST_MODPRV_BIT) begin : g_mp
      assign rdata_o[b] = stat_q_i.modprv;
    end else if (b == ST_TWAIT_BIT) begin : g_tw
      assign rdata_o[b] = stat_q_i.twait;
    end else begin : g_zero
      assign rdata_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/priv_state_regs.sv
module priv_state_regs
  import priv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trap_enter_i,
  input  logic       trap_return_i,
  input  logic       stat_wr_i,
  input  stat_t      wfield_i,
  output logic [1:0] lvl_q_o,
  output logic [1:0] lvl_d_o,
  output stat_t      stat_q_o
);

  logic [1:0] lvl_q, lvl_d;
  stat_t      stat_q, stat_d;
  logic       upd_en;

  assign upd_en = trap_enter_i | trap_return_i | stat_wr_i;

  always_comb begin
    lvl_d  = lvl_q;
    stat_d = stat_q;
    if (trap_enter_i) begin
      lvl_d       = LVL_MACHINE;
      stat_d.plvl = lvl_q;
      stat_d.pie  = stat_q.ie;
      stat_d.ie   = 1'b0;
    end else if (trap_return_i) begin
      lvl_d       = stat_q.plvl;
      stat_d.ie   = stat_q.pie;
      stat_d.pie  = 1'b1;
      stat_d.plvl = LVL_USER;
    end else if (stat_wr_i) begin
      stat_d      = wfield_i;
      stat_d.plvl = legalize_lvl(wfield_i.plvl);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q         <= LVL_MACHINE;
      stat_q.ie     <= 1'b0;
      stat_q.pie    <= 1'b1;
      stat_q.plvl   <= LVL_USER;
      stat_q.modprv <= 1'b0;
      stat_q.twait  <= 1'b0;
    end else if (upd_en) begin
      lvl_q  <= lvl_d;
      stat_q <= stat_d;
    end
  end

  assign lvl_q_o  = lvl_q;
  assign lvl_d_o  = lvl_d;
  assign stat_q_o = stat_q;

  // R2: trap entry lands in machine level and saves the old level and enable
  a_r2_entry_to_machine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_enter_i |=> (lvl_q == LVL_MACHINE) && (stat_q.plvl == $past(lvl_q))
                     && (stat_q.pie == $past(stat_q.ie)) && !stat_q.ie);

  // R3: trap return restores level and enable from the saved copies
  a_r3_return_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_return_i && !trap_enter_i) |=> (lvl_q == $past(stat_q.plvl))
                                       && (stat_q.ie == $past(stat_q.pie)));

  // R4: the saved level never holds an unsupported value
  a_r4_saved_level_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q.plvl == LVL_MACHINE) || (stat_q.plvl == LVL_USER));

  // R11: without any event the state holds
  a_r11_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en |=> $stable(lvl_q) && $stable(stat_q));

endmodule

// File: rtl/priv_rule_check.sv
module priv_rule_check
  import priv_pkg::*;
#(
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         lvl_q_i,
  input  logic               twait_i,
  input  logic               csr_access_i,
  input  logic [1:0]         csr_lvl_field_i,
  input  logic [1:0]         csr_ro_field_i,
  input  logic               csr_write_i,
  input  logic               insn_mret_i,
  input  logic               insn_wfi_i,
  output logic               csr_illegal_o,
  output logic               insn_illegal_o,
  output logic [CAUSE_W-1:0] ecall_cause_o
);

  logic lvl_too_low;
  logic ro_write;
  logic not_machine;

  assign lvl_too_low = csr_lvl_field_i > lvl_q_i;
  assign ro_write    = (csr_ro_field_i == 2'b11) & csr_write_i;
  assign csr_illegal_o = csr_access_i & (lvl_too_low | ro_write);

  assign not_machine    = lvl_q_i != LVL_MACHINE;
  assign insn_illegal_o = not_machine & (insn_mret_i | (twait_i & insn_wfi_i));

  assign ecall_cause_o = not_machine ? CAUSE_W'(CAUSE_ENV_USER)
                                     : CAUSE_W'(CAUSE_ENV_MACHINE);

  // R5: no illegal flag without a requested access
  a_r5_quiet_without_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_access_i |-> !csr_illegal_o);

  // R7: machine level runs every instruction
  a_r7_machine_never_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q_i == LVL_MACHINE) |-> !insn_illegal_o);

  // R8: cause code is one of the two environment-call codes
  a_r8_cause_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecall_cause_o == CAUSE_W'(CAUSE_ENV_USER)) || (ecall_cause_o == CAUSE_W'(CAUSE_ENV_MACHINE)));

endmodule

// File: rtl/priv_view_sel.sv
module priv_view_sel
  import priv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] lvl_q_i,
  input  logic [1:0] lvl_d_i,
  input  logic [1:0] saved_lvl_i,
  input  logic       modprv_i,
  output logic [1:0] fetch_lvl_o,
  output logic [1:0] decode_lvl_o,
  output logic [1:0] lsu_lvl_o
);

  assign fetch_lvl_o  = lvl_d_i;
  assign decode_lvl_o = lvl_q_i;
  assign lsu_lvl_o    = modprv_i ? saved_lvl_i : lvl_q_i;

  // R9: what fetch sees now, decode sees after the edge
  a_r9_fetch_leads_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> decode_lvl_o == $past(fetch_lvl_o));

  // R10: without modify-privilege load/store follows decode
  a_r10_lsu_follows_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !modprv_i |-> (lsu_lvl_o == decode_lvl_o));

endmodule

// File: rtl/priv_mode_tracker.sv
module priv_mode_tracker
  import priv_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_enter_i,
  input  logic               trap_return_i,
  input  logic               status_wr_i,
  input  logic [XLEN-1:0]    status_wdata_i,
  output logic [XLEN-1:0]    status_rdata_o,
  input  logic               csr_access_i,
  input  logic [ADDR_W-1:0]  csr_addr_i,
  input  logic               csr_write_i,
  input  logic               insn_mret_i,
  input  logic               insn_wfi_i,
  output logic               csr_illegal_o,
  output logic               insn_illegal_o,
  output logic [CAUSE_W-1:0] ecall_cause_o,
  output logic [1:0]         priv_fetch_o,
  output logic [1:0]         priv_decode_o,
  output logic [1:0]         priv_lsu_o
);

  // Top two address bits mark read-only, the next two the minimum level
  localparam int unsigned RO_LO  = ADDR_W - 2;
  localparam int unsigned LVL_LO = ADDR_W - 4;

  stat_t      wfield, stat_q;
  logic [1:0] lvl_q, lvl_d;
  logic       unused_addr_low;

  assign unused_addr_low = ^csr_addr_i[LVL_LO-1:0];

  priv_status_io #(.XLEN(XLEN)) u_status_io (
    .wdata_i  (status_wdata_i),
    .stat_q_i (stat_q),
    .wfield_o (wfield),
    .rdata_o  (status_rdata_o)
  );

  priv_state_regs u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trap_enter_i  (trap_enter_i),
    .trap_return_i (trap_return_i),
    .stat_wr_i     (status_wr_i),
    .wfield_i      (wfield),
    .lvl_q_o       (lvl_q),
    .lvl_d_o       (lvl_d),
    .stat_q_o      (stat_q)
  );

  priv_rule_check #(.CAUSE_W(CAUSE_W)) u_rules (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .lvl_q_i         (lvl_q),
    .twait_i         (stat_q.twait),
    .csr_access_i    (csr_access_i),
    .csr_lvl_field_i (csr_addr_i[LVL_LO+1:LVL_LO]),
    .csr_ro_field_i  (csr_addr_i[RO_LO+1:RO_LO]),
    .csr_write_i     (csr_write_i),
    .insn_mret_i     (insn_mret_i),
    .insn_wfi_i      (insn_wfi_i),
    .csr_illegal_o   (csr_illegal_o),
    .insn_illegal_o  (insn_illegal_o),
    .ecall_cause_o   (ecall_cause_o)
  );

  priv_view_sel u_views (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lvl_q_i      (lvl_q),
    .lvl_d_i      (lvl_d),
    .saved_lvl_i  (stat_q.plvl),
    .modprv_i     (stat_q.modprv),
    .fetch_lvl_o  (priv_fetch_o),
    .decode_lvl_o (priv_decode_o),
    .lsu_lvl_o    (priv_lsu_o)
  );

  // R6: a requested write to a read-only address is always flagged
  a_r6_ro_write_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_access_i && csr_write_i && (csr_addr_i[RO_LO+1:RO_LO] == 2'b11)) |-> csr_illegal_o);

  // R1: width configuration is large enough for the status layout
  initial begin
    a_r1_xlen_fits: assert (XLEN >= ST_MIN_XLEN);
  end

endmodule

// File: tb/priv_mode_tracker_tb.sv
module priv_mode_tracker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_ni;
  logic        trap_enter, trap_return, status_wr;
  logic [31:0] status_wdata, status_rdata;
  logic        csr_access, csr_write, insn_mret, insn_wfi;
  logic [11:0] csr_addr;
  logic        csr_illegal, insn_illegal;
  logic [5:0]  ecall_cause;
  logic [1:0]  priv_fetch, priv_decode, priv_lsu;

  int checks = 0;
  int failures = 0;

  // bench model of the architectural state
  logic [1:0] m_lvl, m_plvl;
  logic       m_ie, m_pie, m_mp, m_tw;
  logic [31:0] rng = 32'h1234_5678;

  priv_mode_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .trap_enter_i(trap_enter), .trap_return_i(trap_return),
    .status_wr_i(status_wr), .status_wdata_i(status_wdata),
    .status_rdata_o(status_rdata),
    .csr_access_i(csr_access), .csr_addr_i(csr_addr), .csr_write_i(csr_write),
    .insn_mret_i(insn_mret), .insn_wfi_i(insn_wfi),
    .csr_illegal_o(csr_illegal), .insn_illegal_o(insn_illegal),
    .ecall_cause_o(ecall_cause),
    .priv_fetch_o(priv_fetch), .priv_decode_o(priv_decode), .priv_lsu_o(priv_lsu)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    s[3] = m_ie; s[7] = m_pie; s[12:11] = m_plvl; s[17] = m_mp; s[21] = m_tw;
    return s;
  endfunction

  function automatic logic [1:0] m_next_lvl(input logic en, input logic rt);
    if (en) return 2'b11;
    if (rt) return m_plvl;
    return m_lvl;
  endfunction

  task automatic model_step(input logic en, input logic rt, input logic wr, input logic [31:0] wd);
    logic [1:0] ol = m_lvl, op = m_plvl;
    logic oie = m_ie, opie = m_pie;
    if (en) begin
      m_lvl = 2'b11; m_plvl = ol; m_pie = oie; m_ie = 1'b0;
    end else if (rt) begin
      m_lvl = op; m_ie = opie; m_pie = 1'b1; m_plvl = 2'b00;
    end else if (wr) begin
      m_ie = wd[3]; m_pie = wd[7]; m_mp = wd[17]; m_tw = wd[21];
      m_plvl = (wd[12:11] == 2'b11 || wd[12:11] == 2'b00) ? wd[12:11] : 2'b11;
    end
  endtask

  task automatic check_state(input string tag);
    chk(tag, status_rdata, m_status());
    chk("R9 decode view", {30'd0, priv_decode}, {30'd0, m_lvl});
    chk("R10 lsu view", {30'd0, priv_lsu}, {30'd0, m_mp ? m_plvl : m_lvl});
  endtask

  task automatic do_cycle(input string tag, input logic en, input logic rt,
                          input logic wr, input logic [31:0] wd);
    @(negedge clk);
    trap_enter = en; trap_return = rt; status_wr = wr; status_wdata = wd;
    #1;
    chk("R9 fetch view is next level", {30'd0, priv_fetch}, {30'd0, m_next_lvl(en, rt)});
    @(posedge clk);
    #1;
    model_step(en, rt, wr, wd);
    trap_enter = 1'b0; trap_return = 1'b0; status_wr = 1'b0; status_wdata = '0;
    check_state(tag);
  endtask

  task automatic probe(input logic acc, input logic [11:0] addr, input logic wr,
                       input logic mret, input logic wfi);
    logic exp_csr, exp_ins;
    @(negedge clk);
    csr_access = acc; csr_addr = addr; csr_write = wr; insn_mret = mret; insn_wfi = wfi;
    #1;
    exp_csr = acc && ((addr[9:8] > m_lvl) || (addr[11:10] == 2'b11 && wr));
    exp_ins = (m_lvl != 2'b11) && (mret || (m_tw && wfi));
    chk("R5 R6 csr illegal flag", {31'd0, csr_illegal}, {31'd0, exp_csr});
    chk("R7 instruction illegal flag", {31'd0, insn_illegal}, {31'd0, exp_ins});
    chk("R8 ecall cause", {26'd0, ecall_cause}, (m_lvl == 2'b11) ? 32'd11 : 32'd8);
    csr_access = 1'b0; csr_write = 1'b0; insn_mret = 1'b0; insn_wfi = 1'b0;
  endtask

  task automatic sweep_rules();
    for (int a = 0; a < 16; a++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 2; c++)
          probe(c[0], {a[3:0], 8'h5A ^ a[7:0]}, w[0], a[0], a[1]);
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 run did not end actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    trap_enter = 0; trap_return = 0; status_wr = 0; status_wdata = '0;
    csr_access = 0; csr_addr = '0; csr_write = 0; insn_mret = 0; insn_wfi = 0;
    m_lvl = 2'b11; m_plvl = 2'b00; m_ie = 0; m_pie = 1; m_mp = 0; m_tw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 reset status", status_rdata, 32'h0000_0080);
    chk("R1 reset decode level", {30'd0, priv_decode}, 32'd3);
    chk("R1 reset fetch level", {30'd0, priv_fetch}, 32'd3);
    chk("R1 reset lsu level", {30'd0, priv_lsu}, 32'd3);

    sweep_rules();  // machine, trap-wait clear

    // R4: every saved-level code with all other bits set
    for (int v = 0; v < 4; v++)
      do_cycle("R4 write legalize and mask", 1'b0, 1'b0, 1'b1,
               32'hFFFF_E7FF | (32'(v) << 11));

    // enter user level with trap-wait set
    do_cycle("R4 write setup", 1'b0, 1'b0, 1'b1, 32'h0020_0000);
    do_cycle("R3 return to user", 1'b0, 1'b1, 1'b0, '0);
    sweep_rules();  // user, trap-wait set
    do_cycle("R4 write in user", 1'b0, 1'b0, 1'b1, 32'h0000_0088);
    sweep_rules();  // user, trap-wait clear
    do_cycle("R2 trap entry from user", 1'b1, 1'b0, 1'b0, '0);
    sweep_rules();  // machine again

    // R11: all event combinations from both levels
    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 2; l++) begin
        if (l == 1) begin
          do_cycle("R4 write setup", 1'b0, 1'b0, 1'b1, 32'h0000_0000);
          do_cycle("R3 return setup", 1'b0, 1'b1, 1'b0, '0);
        end else begin
          do_cycle("R2 entry setup", 1'b1, 1'b0, 1'b0, '0);
        end
        do_cycle("R11 event priority", c[0], c[1], c[2], 32'h0022_1888);
      end
    end

    // pseudo-random mix
    for (int i = 0; i < 1500; i++) begin
      rng = next_rng(rng);
      do_cycle("R11 random events", rng[2:0] == 3'd0, rng[5:3] < 3'd2, rng[6],
               {rng[31:7], rng[6:0]} ^ {rng[15:0], rng[31:16]});
      probe(rng[8], rng[27:16], rng[9], rng[10], rng[11]);
    end

    finish_run();
  end

endmodule